// File: doc/BRIEF.md
# Load-Ordering Snoop Guard

This block keeps an in-order ring of the loads a speculative, out-of-order core has in flight. The front end claims a slot for each load at dispatch, in program order. When the load executes and its data comes back, the execute stage records the load's address in its slot. The commit stage frees slots in order from the oldest end. Under a total-store-order memory model, loads must look as if they completed in program order. A younger load that has already returned data is therefore exposed if another core invalidates its cache line before the load commits.

Each incoming coherence invalidation is compared, by 64-byte line, against every slot whose load has returned data but has not yet committed. On a hit, the block sends the pipeline a one-cycle clear request that carries the slot index of the oldest hit. The pipeline then flushes and refetches from that load. In the same cycle the block discards that slot and every younger one, and moves its allocation point back to the named slot, so that re-dispatch fills the ring again from there. No further clears are raised until the pipeline reports that the flush is done.

Dispatch and commit use valid/ready handshakes. A dispatch transfers when `disp_valid` and `disp_ready` are both high. `disp_ready` drops when the ring is full or a flush is pending. A commit transfers when `ret_valid` and `ret_ready` are both high, and `ret_ready` is high whenever at least one slot is occupied. Execute reports and snoops have no back-pressure and are sampled on every cycle their valid is high.

Top module: `ldq_snoop_guard`

## Requirements
- R1: After reset the ring is empty: `disp_ready`=1, `ret_ready`=0, `clr_valid`=0 and `disp_idx`=0.
- R2: Each accepted dispatch takes the slot shown on `disp_idx`, and successive dispatches receive consecutive indices, modulo the depth.
- R3: After DEPTH (16) dispatches with no commit, `disp_ready` is 0 and a held `disp_valid` is not accepted. One commit makes `disp_ready` 1 again.
- R4: A snoop whose address bits [31:6] equal those of a slot that has returned data and has not committed makes `clr_valid` high in the cycle after the snoop, with `clr_idx` naming that slot. Address bits [5:0] are ignored.
- R5: A snoop does not raise a clear when it matches only a slot whose load has not returned data, a slot whose load has already committed, or no slot at all.
- R6: When several slots match one snoop, `clr_idx` names the slot nearest the commit end in program order, with wraparound taken into account.
- R7: A clear discards the named slot and all younger slots. The next dispatch receives the named index, and `ret_ready` reflects only the older slots that remain.
- R8: When a commit and a snoop fall in the same cycle, the commit is applied first, so the committing load cannot be named. A younger match in that cycle is still reported.
- R9: `clr_valid` is high for exactly one cycle. From that cycle until `flush_done` is high, `disp_ready` is 0 and snoops raise no clear. A dispatch accepted in the same cycle as a clear is discarded with the flushed loads.
- R10: An execute report for a slot that is not occupied is ignored: a later snoop on its address raises no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Front end offers a load for allocation |
| disp_ready | output | 1 | A slot is free and no flush is pending |
| disp_idx | output | 4 | Slot the next accepted dispatch takes |
| exe_valid | input | 1 | A load has returned data |
| exe_idx | input | 4 | Slot of the returning load |
| exe_addr | input | 32 | Address of the returning load |
| ret_valid | input | 1 | Commit stage retires the oldest load |
| ret_ready | output | 1 | At least one slot is occupied |
| snp_valid | input | 1 | Invalidation from another core |
| snp_addr | input | 32 | Address of the invalidated line |
| flush_done | input | 1 | Pipeline has finished the requested flush |
| clr_valid | output | 1 | One-cycle machine-clear request |
| clr_idx | output | 4 | Slot of the oldest load to refetch from |

## Verification
The commit of the oldest load and an invalidation snoop can fall in the same cycle. That is the ordering this block resolves itself. The bench provokes it twice by holding `ret_valid` and `snp_valid` together for one clock. In the first case the snoop hits only the committing load, and no clear may appear. In the second case a younger slot on the same line also matches, and the scoreboard expects a clear that names the younger slot. After the clear, `ret_ready` shows that the ring was emptied.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

  typedef enum logic {
    FL_IDLE = 1'b0,
    FL_WAIT = 1'b1
  } flush_state_e;

endpackage

// File: rtl/ldq_oldest_pick.sv
module ldq_oldest_pick #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req_vec,
  input  logic [IDX_W-1:0] base,
  output logic             found,
  output logic [IDX_W-1:0] pick
);

  logic [IDX_W-1:0] probe;

  // scan from the oldest slot forward; first hit wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    probe = '0;
    for (int k = 0; k < DEPTH; k++) begin
      probe = base + IDX_W'(k);
      if (!found && req_vec[probe]) begin
        found = 1'b1;
        pick  = probe;
      end
    end
  end

  always_comb begin
    if (found) begin
      AST_PICK_IS_REQ: assert (req_vec[pick]); // R6
    end
  end

endmodule

// File: rtl/ldq_ptr_ctrl.sv
module ldq_ptr_ctrl #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic             ret_en,
  input  logic             rewind_en,
  input  logic [IDX_W-1:0] rewind_idx,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [IDX_W-1:0] head_nx;

  assign head_nx = ret_en ? head + IDX_W'(1) : head;
  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head <= head_nx;
      if (rewind_en) begin
        tail  <= rewind_idx;
        count <= {1'b0, rewind_idx - head_nx};
      end else begin
        if (alloc_en) tail <= tail + IDX_W'(1);
        count <= count + CNT_W'(alloc_en) - CNT_W'(ret_en);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_en); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !ret_en); // R7

endmodule

// File: rtl/ldq_entry_array.sv
module ldq_entry_array #(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic              exe_en,
  input  logic [IDX_W-1:0]  exe_idx,
  input  logic [LINE_W-1:0] exe_line,
  input  logic              ret_en,
  input  logic [IDX_W-1:0]  ret_idx,
  input  logic [DEPTH-1:0]  kill_mask,
  input  logic [LINE_W-1:0] snp_line,
  output logic [DEPTH-1:0]  valid_vec,
  output logic [DEPTH-1:0]  hit_vec
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              occ_q;
    logic              done_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ_q  <= 1'b0;
        done_q <= 1'b0;
      end else if (kill_mask[i]) begin
        occ_q  <= 1'b0;
        done_q <= 1'b0;
      end else if (ret_en && ret_idx == IDX_W'(i)) begin
        occ_q  <= 1'b0;
        done_q <= 1'b0;
      end else if (alloc_en && alloc_idx == IDX_W'(i)) begin
        occ_q  <= 1'b1;
        done_q <= 1'b0;
      end else if (exe_en && exe_idx == IDX_W'(i) && occ_q) begin
        done_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (exe_en && exe_idx == IDX_W'(i) && occ_q && !kill_mask[i]) begin
        line_q <= exe_line;
      end
    end

    assign valid_vec[i] = occ_q;
    assign hit_vec[i]   = occ_q && done_q && (line_q == snp_line);

    AST_KILL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      kill_mask[i] |=> !occ_q); // R7
    AST_DONE_NEEDS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> occ_q); // R5
  end

endmodule

// File: rtl/ldq_snoop_guard.sv
module ldq_snoop_guard #(
  parameter int DEPTH    = 16,
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = IDX_W + 1,
  localparam int LINE_W  = ADDR_W - LINE_OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  output logic              disp_ready,
  output logic [IDX_W-1:0]  disp_idx,
  input  logic              exe_valid,
  input  logic [IDX_W-1:0]  exe_idx,
  input  logic [ADDR_W-1:0] exe_addr,
  input  logic              ret_valid,
  output logic              ret_ready,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              flush_done,
  output logic              clr_valid,
  output logic [IDX_W-1:0]  clr_idx
);
  import ldq_pkg::*;

  flush_state_e     fl_q;
  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic             full, empty;
  logic [DEPTH-1:0] valid_vec, hit_vec, cand_vec, kill_mask;
  logic             found;
  logic [IDX_W-1:0] pick, pick_age;
  logic             disp_fire, ret_fire, alloc_en, clr_fire, snp_live;
  logic             clr_valid_q;
  logic [IDX_W-1:0] clr_idx_q;
  logic             unused_low;

  assign unused_low = ^{exe_addr[LINE_OFS-1:0], snp_addr[LINE_OFS-1:0]};

  assign disp_ready = !full && (fl_q == FL_IDLE);
  assign disp_idx   = tail;
  assign ret_ready  = !empty;
  assign disp_fire  = disp_valid && disp_ready;
  assign ret_fire   = ret_valid && ret_ready;
  assign snp_live   = snp_valid && (fl_q == FL_IDLE);

  // commit wins over snoop: the slot leaving this cycle is not a candidate
  always_comb begin
    cand_vec = hit_vec;
    if (ret_fire) cand_vec[head] = 1'b0;
  end

  ldq_oldest_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .req_vec (cand_vec),
    .base    (head),
    .found   (found),
    .pick    (pick)
  );

  assign clr_fire = snp_live && found;
  assign alloc_en = disp_fire && !clr_fire;
  assign pick_age = pick - head;

  for (genvar i = 0; i < DEPTH; i++) begin : g_kill
    logic [IDX_W-1:0] age;
    assign age          = IDX_W'(i) - head;
    assign kill_mask[i] = clr_fire && valid_vec[i] && (age >= pick_age);
  end

  ldq_entry_array #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_en),
    .alloc_idx (tail),
    .exe_en    (exe_valid),
    .exe_idx   (exe_idx),
    .exe_line  (exe_addr[ADDR_W-1:LINE_OFS]),
    .ret_en    (ret_fire),
    .ret_idx   (head),
    .kill_mask (kill_mask),
    .snp_line  (snp_addr[ADDR_W-1:LINE_OFS]),
    .valid_vec (valid_vec),
    .hit_vec   (hit_vec)
  );

  ldq_ptr_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (alloc_en),
    .ret_en     (ret_fire),
    .rewind_en  (clr_fire),
    .rewind_idx (pick),
    .head       (head),
    .tail       (tail),
    .count      (count),
    .full       (full),
    .empty      (empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_q        <= FL_IDLE;
      clr_valid_q <= 1'b0;
      clr_idx_q   <= '0;
    end else begin
      clr_valid_q <= clr_fire;
      if (clr_fire) clr_idx_q <= pick;
      case (fl_q)
        FL_IDLE: if (clr_fire)   fl_q <= FL_WAIT;
        FL_WAIT: if (flush_done) fl_q <= FL_IDLE;
        default:                 fl_q <= FL_IDLE;
      endcase
    end
  end

  assign clr_valid = clr_valid_q;
  assign clr_idx   = clr_idx_q;

  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> !clr_valid); // R9
  AST_CLR_FROM_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> $past(snp_valid)); // R4
  AST_CLR_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> (tail == clr_idx)); // R7
  AST_HOLD_NO_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_q == FL_WAIT) |-> !disp_ready); // R9
  AST_CLR_NOT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> ($past(fl_q) == FL_IDLE)); // R9

endmodule

// File: tb/ldq_snoop_guard_tb.sv
`timescale 1ns/1ps
module ldq_snoop_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0, exe_valid = 1'b0, ret_valid = 1'b0;
  logic        snp_valid = 1'b0, flush_done = 1'b0;
  logic [3:0]  exe_idx = '0;
  logic [31:0] exe_addr = '0, snp_addr = '0;
  logic        disp_ready, ret_ready, clr_valid;
  logic [3:0]  disp_idx, clr_idx;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #2 clk = ~clk;

  ldq_snoop_guard u_dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_idx(disp_idx),
    .exe_valid(exe_valid), .exe_idx(exe_idx), .exe_addr(exe_addr),
    .ret_valid(ret_valid), .ret_ready(ret_ready),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .flush_done(flush_done),
    .clr_valid(clr_valid), .clr_idx(clr_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // monitor: every clear must match the next expected index
  always @(negedge clk) begin
    if (rst_n && clr_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected clear", int'(clr_idx), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(clr_idx) == e, "R4/R6 clear index", int'(clr_idx), e);
      end
    end
  end

  task automatic dispatch(input int exp, input string req);
    disp_valid = 1'b1;
    chk(disp_ready == 1'b1, {req, " ready"}, int'(disp_ready), 1);
    chk(int'(disp_idx) == exp, {req, " index"}, int'(disp_idx), exp);
    tick();
    disp_valid = 1'b0;
  endtask

  task automatic execute(input int idx, input logic [31:0] a);
    exe_valid = 1'b1; exe_idx = 4'(idx); exe_addr = a;
    tick();
    exe_valid = 1'b0;
  endtask

  task automatic snoop(input logic [31:0] a, input bit with_ret);
    snp_valid = 1'b1; snp_addr = a; ret_valid = with_ret;
    tick();
    snp_valid = 1'b0; ret_valid = 1'b0;
  endtask

  task automatic retire();
    ret_valid = 1'b1;
    tick();
    ret_valid = 1'b0;
  endtask

  task automatic release_flush();
    flush_done = 1'b1;
    tick();
    flush_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(disp_ready == 1'b1, "R1 disp_ready", int'(disp_ready), 1);
    chk(ret_ready == 1'b0, "R1 ret_ready", int'(ret_ready), 0);
    chk(clr_valid == 1'b0, "R1 clr_valid", int'(clr_valid), 0);
    chk(disp_idx == 4'd0, "R1 disp_idx", int'(disp_idx), 0);

    // R2 program-order allocation
    for (int k = 0; k < 4; k++) dispatch(k, "R2");
    execute(1, 32'h0000_1000);
    execute(3, 32'h0000_1004);
    // R5: no slot on this line, slot 0 never executed
    snoop(32'h0000_8000, 1'b0);
    chk(clr_valid == 1'b0, "R5 no match", int'(clr_valid), 0);
    // R4/R6: low bits ignored, slot 1 older than slot 3
    exp_q.push_back(1);
    snoop(32'h0000_103F, 1'b0);
    chk(clr_valid == 1'b1, "R4 clear raised", int'(clr_valid), 1);
    chk(disp_ready == 1'b0, "R9 hold blocks dispatch", int'(disp_ready), 0);
    tick();
    chk(clr_valid == 1'b0, "R9 single pulse", int'(clr_valid), 0);
    snoop(32'h0000_1000, 1'b0);
    chk(clr_valid == 1'b0, "R9 snoop during hold", int'(clr_valid), 0);
    release_flush();
    chk(disp_ready == 1'b1, "R9 hold released", int'(disp_ready), 1);

    // R10: slot 3 was flushed; execute report ignored
    execute(3, 32'h0000_2000);
    snoop(32'h0000_2000, 1'b0);
    chk(clr_valid == 1'b0, "R10 stale execute", int'(clr_valid), 0);
    // R7: re-dispatch starts at the named slot
    dispatch(1, "R7");
    execute(0, 32'h0000_3000);
    execute(1, 32'h0000_3040);
    retire();
    retire();
    chk(ret_ready == 1'b0, "R7 only older slot kept", int'(ret_ready), 0);
    // R5: committed loads no longer match
    snoop(32'h0000_3000, 1'b0);
    chk(clr_valid == 1'b0, "R5 committed load", int'(clr_valid), 0);

    // R8: commit and snoop together
    dispatch(2, "R8");
    execute(2, 32'h0000_4000);
    snoop(32'h0000_4000, 1'b1);
    chk(clr_valid == 1'b0, "R8 committing load not named", int'(clr_valid), 0);
    chk(ret_ready == 1'b0, "R8 commit applied", int'(ret_ready), 0);
    dispatch(3, "R8");
    dispatch(4, "R8");
    execute(3, 32'h0000_5000);
    execute(4, 32'h0000_5010);
    exp_q.push_back(4);
    snoop(32'h0000_5000, 1'b1);
    chk(clr_valid == 1'b1, "R8 younger still cleared", int'(clr_valid), 1);
    chk(ret_ready == 1'b0, "R8 ring emptied", int'(ret_ready), 0);
    release_flush();

    // R3: fill from head 4
    for (int k = 0; k < 16; k++) dispatch((4 + k) % 16, "R3");
    chk(disp_ready == 1'b0, "R3 full", int'(disp_ready), 0);
    disp_valid = 1'b1;
    tick();
    disp_valid = 1'b0;
    chk(disp_idx == 4'd4, "R3 held dispatch refused", int'(disp_idx), 4);
    retire();
    chk(disp_ready == 1'b1, "R3 commit frees slot", int'(disp_ready), 1);
    dispatch(4, "R3");

    // R6 with wraparound: head 5, slot 15 older than slot 0
    execute(0, 32'h0000_6020);
    execute(15, 32'h0000_6000);
    exp_q.push_back(15);
    snoop(32'h0000_6000, 1'b0);
    release_flush();
    dispatch(15, "R7 rewind");
    for (int k = 0; k < 11; k++) retire();
    chk(ret_ready == 1'b0, "R7 survivors counted", int'(ret_ready), 0);

    tick();
    chk(exp_q.size() == 0, "R4 missing clear", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule